// File: doc/BRIEF.md
# Display Control Word and RAM Clear Sequencer

This block keeps the 8-bit control word of an eight-character dot-matrix display controller. It also runs the hardware operations that control word can start. A host reaches it over a plain byte bus with a select, a write strobe, a read strobe, a 2-bit space code, a location address and a data byte. Through that bus the host can write the character RAM, write the flash-attribute RAM, or write and read the control word. The block owns the write ports of both RAMs. Host writes pass through those ports while the block is idle. The block's own sequencer takes the ports over when it fills the RAMs.

A fill writes the space code 0x20 into every character location and 0 into every flash location, one location per clock. A fill starts in three ways: when reset is released, when the host sets the clear bit, or at the end of a self test. The self test writes two complementary patterns to one character location and reads each back. It then fills, and it stores the outcome in a result bit that the host cannot write. While the block is busy it ignores host writes. The decoded blink, flash and brightness fields go straight to the scan logic.

Top module: `dispctl_top`

## Requirements
- R1: While `rst_n` is low, `busy` is 1 and the control word reads 0x00. After release, `busy` stays high for exactly DEPTH clock cycles, and at the end every character location holds 0x20 and every flash location holds 0.
- R2: An accepted control write with bit 7 = 1 starts a fill. `busy` is high for exactly DEPTH cycles after the write edge, and afterwards all character locations hold 0x20 and all flash locations hold 0.
- R3: During a fill, bit 7 reads back as 1. It returns to 0 when the fill ends. Bits 4..0 written in the same word are kept.
- R4: Host writes of any space that arrive while `busy` is 1 change neither RAM nor the control word.
- R5: Bit 5 (self-test result) is read-only. A host write leaves its current value unchanged.
- R6: `blink_en` equals bit 4. `flash_en` equals bit 3 AND NOT bit 4, so blink overrides flash.
- R7: `bright` equals control bits 2..0.
- R8: An accepted control write with bit 6 = 1 runs a self test. `busy` is high for DEPTH+4 cycles. Location 0 is written with 0xA5 and read back, then written with 0x5A and read back. The RAMs are then filled. At the end, bit 6 = 0 and bit 5 = 1 if both readbacks matched.
- R9: If either self-test readback mismatches, bit 5 ends at 0.
- R10: With `bus_sel`=1, `bus_wr`=1 and the block idle, space 00 writes `bus_wdata` to character location `bus_addr`, and space 01 writes `bus_wdata[0]` to flash location `bus_addr`. With `bus_sel`=0 nothing is written.
- R11: `bus_rdata` returns the control word when `bus_sel`=1, `bus_rd`=1 and space = 10. Otherwise it is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one fill location per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Host select, active high |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_space | input | 2 | 00 character RAM, 01 flash RAM, 10 control word, 11 none |
| bus_addr | input | AW | RAM location for host writes |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Control word readback |
| busy | output | 1 | High during reset, fill and self test |
| blink_en | output | 1 | Blink enable |
| flash_en | output | 1 | Flash enable, masked by blink |
| bright | output | 3 | Brightness code |
| test_pass | output | 1 | Self-test result bit |
| chr_we | output | 1 | Character RAM write enable |
| chr_addr | output | AW | Character RAM write address |
| chr_wdata | output | 8 | Character RAM write data |
| chr_raddr | output | AW | Character RAM read address for self test |
| chr_rdata | input | 8 | Character RAM read data (asynchronous) |
| fla_we | output | 1 | Flash RAM write enable |
| fla_addr | output | AW | Flash RAM write address |
| fla_wdata | output | FLASH_W | Flash RAM write data |

## Verification
The bench first fills the RAMs with non-blank data. That way a fill that skips the last location, or that stops one cycle early, leaves a visible stale byte and a wrong busy length. It writes the control word while a fill is running. A design that lets host writes through during busy would leave a host byte in a cleared location or a changed brightness. It sets the clear bit together with other fields, which catches a design that wipes the whole word rather than just bit 7. It also writes bit 5 directly, which catches a design that lets the host overwrite the result bit. A fault injected in the RAM model's readback must drive the result bit to 0. Combined blink-and-flash settings check that blink masks flash.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_TW1, SQ_TR1, SQ_TW2, SQ_TR2, SQ_FILL
  } seq_state_t;

  localparam logic [1:0] SP_CHR = 2'b00;
  localparam logic [1:0] SP_FLA = 2'b01;
  localparam logic [1:0] SP_CTL = 2'b10;

  localparam int B_CLR = 7;
  localparam int B_TST = 6;
  localparam int B_RES = 5;
  localparam int B_BLK = 4;
  localparam int B_FLS = 3;

  localparam logic [7:0] FILL_CHAR = 8'h20;
  localparam logic [7:0] PAT_A     = 8'hA5;
  localparam logic [7:0] PAT_B     = 8'h5A;
  localparam logic [7:0] RES_MASK  = 8'h20;
endpackage

// File: rtl/dispctl_seq.sv
module dispctl_seq
  import dispctl_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_clear,
  input  logic          start_test,
  input  logic [7:0]    rd_data,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          we_chr,
  output logic          we_fla,
  output logic [AW-1:0] addr,
  output logic [7:0]    chr_data
);
  localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);
  localparam logic [AW-1:0] TST_ADDR = '0;

  seq_state_t    st;
  logic [AW-1:0] cnt;
  logic          pass_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SQ_FILL;
      cnt    <= '0;
      pass_q <= 1'b0;
    end else begin
      case (st)
        SQ_IDLE: begin
          if (start_test) begin
            st     <= SQ_TW1;
            pass_q <= 1'b1;
          end else if (start_clear) begin
            st  <= SQ_FILL;
            cnt <= '0;
          end
        end
        SQ_TW1: st <= SQ_TR1;
        SQ_TR1: begin
          pass_q <= pass_q & (rd_data == PAT_A);
          st     <= SQ_TW2;
        end
        SQ_TW2: st <= SQ_TR2;
        SQ_TR2: begin
          pass_q <= pass_q & (rd_data == PAT_B);
          st     <= SQ_FILL;
          cnt    <= '0;
        end
        SQ_FILL: begin
          if (cnt == LAST) begin
            st  <= SQ_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    busy     = (st != SQ_IDLE);
    done     = (st == SQ_FILL) && (cnt == LAST);
    pass     = pass_q;
    we_chr   = (st == SQ_TW1) || (st == SQ_TW2) || (st == SQ_FILL);
    we_fla   = (st == SQ_FILL);
    addr     = (st == SQ_FILL) ? cnt : TST_ADDR;
    chr_data = (st == SQ_FILL) ? FILL_CHAR : ((st == SQ_TW1) ? PAT_A : PAT_B);
  end
endmodule

// File: rtl/dispctl_ctlreg.sv
module dispctl_ctlreg
  import dispctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ok,
  input  logic [7:0] wdata,
  input  logic       done,
  input  logic       pass,
  output logic [7:0] ctl_q,
  output logic       blink_en,
  output logic       flash_en,
  output logic [2:0] bright,
  output logic       test_pass
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wr_ok) begin
      ctl_q <= (wdata & ~RES_MASK) | (ctl_q & RES_MASK);
    end else if (done) begin
      ctl_q[B_CLR] <= 1'b0;
      if (ctl_q[B_TST]) begin
        ctl_q[B_TST] <= 1'b0;
        ctl_q[B_RES] <= pass;
      end
    end
  end

  always_comb begin
    blink_en  = ctl_q[B_BLK];
    flash_en  = ctl_q[B_FLS] & ~ctl_q[B_BLK];
    bright    = ctl_q[2:0];
    test_pass = ctl_q[B_RES];
  end
endmodule

// File: rtl/dispctl_wrport.sv
module dispctl_wrport #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          seq_own,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_data,
  input  logic          seq_we,
  input  logic [AW-1:0] seq_addr,
  input  logic [DW-1:0] seq_data,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  always_comb begin
    if (seq_own) begin
      we   = seq_we;
      addr = seq_addr;
      data = seq_data;
    end else begin
      we   = host_we;
      addr = host_addr;
      data = host_data;
    end
  end
endmodule

// File: rtl/dispctl_top.sv
module dispctl_top
  import dispctl_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int FLASH_W = 1,
  parameter int AW      = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [1:0]         bus_space,
  input  logic [AW-1:0]      bus_addr,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  output logic               busy,
  output logic               blink_en,
  output logic               flash_en,
  output logic [2:0]         bright,
  output logic               test_pass,
  output logic               chr_we,
  output logic [AW-1:0]      chr_addr,
  output logic [7:0]         chr_wdata,
  output logic [AW-1:0]      chr_raddr,
  input  logic [7:0]         chr_rdata,
  output logic               fla_we,
  output logic [AW-1:0]      fla_addr,
  output logic [FLASH_W-1:0] fla_wdata
);
  logic          acc, wr_ctl, start_clear, start_test;
  logic          h_chr, h_fla;
  logic          seq_done, seq_pass, seq_we_chr, seq_we_fla;
  logic [AW-1:0] seq_addr;
  logic [7:0]    seq_chr_data;
  logic [7:0]    ctl_q;

  always_comb begin
    acc         = bus_sel & bus_wr & ~busy;
    wr_ctl      = acc & (bus_space == SP_CTL);
    h_chr       = acc & (bus_space == SP_CHR);
    h_fla       = acc & (bus_space == SP_FLA);
    start_clear = wr_ctl & bus_wdata[B_CLR];
    start_test  = wr_ctl & bus_wdata[B_TST];
    bus_rdata   = (bus_sel & bus_rd & (bus_space == SP_CTL)) ? ctl_q : 8'h00;
    chr_raddr   = '0;
  end

  dispctl_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_clear(start_clear), .start_test(start_test),
    .rd_data(chr_rdata),
    .busy(busy), .done(seq_done), .pass(seq_pass),
    .we_chr(seq_we_chr), .we_fla(seq_we_fla),
    .addr(seq_addr), .chr_data(seq_chr_data)
  );

  dispctl_ctlreg u_ctl (
    .clk(clk), .rst_n(rst_n),
    .wr_ok(wr_ctl), .wdata(bus_wdata),
    .done(seq_done), .pass(seq_pass),
    .ctl_q(ctl_q),
    .blink_en(blink_en), .flash_en(flash_en),
    .bright(bright), .test_pass(test_pass)
  );

  dispctl_wrport #(.DW(8), .AW(AW)) u_chr_port (
    .seq_own(busy),
    .host_we(h_chr), .host_addr(bus_addr), .host_data(bus_wdata),
    .seq_we(seq_we_chr), .seq_addr(seq_addr), .seq_data(seq_chr_data),
    .we(chr_we), .addr(chr_addr), .data(chr_wdata)
  );

  dispctl_wrport #(.DW(FLASH_W), .AW(AW)) u_fla_port (
    .seq_own(busy),
    .host_we(h_fla), .host_addr(bus_addr), .host_data(bus_wdata[FLASH_W-1:0]),
    .seq_we(seq_we_fla), .seq_addr(seq_addr), .seq_data('0),
    .we(fla_we), .addr(fla_addr), .data(fla_wdata)
  );
endmodule

// File: rtl/dispctl_chk.sv
module dispctl_chk
  import dispctl_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int FLASH_W = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic [7:0]         ctl_q,
  input logic               blink_en,
  input logic               flash_en,
  input logic               fla_we,
  input logic [7:0]         chr_wdata,
  input logic [FLASH_W-1:0] fla_wdata
);
  localparam int MAXRUN = DEPTH + 4;
  logic [15:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;
  end

  // R2: every fill write carries blank data
  p_fill_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fla_we) |-> (chr_wdata == FILL_CHAR && fla_wdata == '0));

  // R2, R8: no busy stretch exceeds the self-test length
  p_busy_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run < 16'(MAXRUN)));

  // R3: clear bit is low once the sequencer goes idle
  p_clear_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !ctl_q[B_CLR]);

  // R8: test request bit is low once the sequencer goes idle
  p_test_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !ctl_q[B_TST]);

  // R4: low control fields hold while busy
  p_hold_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (ctl_q[4:0] == $past(ctl_q[4:0])));

  // R6: blink masks flash
  p_blink_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    blink_en |-> !flash_en);
endmodule

bind dispctl_top dispctl_chk #(.DEPTH(DEPTH), .FLASH_W(FLASH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ctl_q(ctl_q),
  .blink_en(blink_en), .flash_en(flash_en), .fla_we(fla_we),
  .chr_wdata(chr_wdata), .fla_wdata(fla_wdata)
);

// File: tb/sim_dispctl_top.sv
module sim_dispctl_top;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, wr_s = 1'b0, rd_s = 1'b0, fault = 1'b0;
  logic [1:0] space = 2'b11;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, chr_wdata, chr_rdata;
  logic       busy, blink_en, flash_en, test_pass, chr_we, fla_we;
  logic [2:0] bright, chr_addr, chr_raddr, fla_addr;
  logic [0:0] fla_wdata;
  logic [7:0] cmem [DEPTH];
  logic       fmem [DEPTH];
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dispctl_top #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr_s), .bus_rd(rd_s),
    .bus_space(space), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .busy(busy), .blink_en(blink_en), .flash_en(flash_en), .bright(bright),
    .test_pass(test_pass), .chr_we(chr_we), .chr_addr(chr_addr),
    .chr_wdata(chr_wdata), .chr_raddr(chr_raddr), .chr_rdata(chr_rdata),
    .fla_we(fla_we), .fla_addr(fla_addr), .fla_wdata(fla_wdata)
  );

  always @(posedge clk) begin
    if (chr_we) cmem[chr_addr] <= chr_wdata;
    if (fla_we) fmem[fla_addr] <= fla_wdata[0];
  end
  assign chr_rdata = cmem[chr_raddr] ^ {7'b0, fault};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sp, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1; wr_s = 1; space = sp; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; wr_s = 0; space = 2'b11;
    #1;
  endtask

  task automatic rd(input logic [1:0] sp, output logic [7:0] v);
    sel = 1; rd_s = 1; space = sp;
    #1 v = rdata;
    sel = 0; rd_s = 0; space = 2'b11;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk); #1;
    end
  endtask

  task automatic chk_blank(input string req);
    int bad = 0;
    for (int i = 0; i < DEPTH; i++)
      if (cmem[i] !== 8'h20 || fmem[i] !== 1'b0) bad++;
    chk(req, bad, 0);
  endtask

  task automatic t_reset;
    logic [7:0] v; int n;
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 busy in reset", busy, 1);
    rd(2'b10, v);
    chk("R1 ctl in reset", v, 8'h00);
    @(negedge clk); rst_n = 1; #1;
    count_busy(n);
    chk("R1 busy length", n, DEPTH);
    chk_blank("R1 ram blank");
  endtask

  task automatic t_host_ram;
    wr(2'b00, 3'd5, 8'h41);
    chk("R10 char write", cmem[5], 8'h41);
    wr(2'b01, 3'd2, 8'h01);
    chk("R10 flash write", fmem[2], 1);
    @(negedge clk); sel = 0; wr_s = 1; space = 2'b00; addr = 3'd5; wdata = 8'h77;
    @(negedge clk); wr_s = 0; #1;
    chk("R10 no sel", cmem[5], 8'h41);
    for (int i = 0; i < DEPTH; i++) begin
      wr(2'b00, 3'(i), 8'h30 + 8'(i));
      wr(2'b01, 3'(i), 8'h01);
    end
  endtask

  task automatic t_clear;
    logic [7:0] v; int n;
    wr(2'b10, 3'd0, 8'h9A);
    rd(2'b10, v);
    chk("R3 bit7 during fill", v, 8'h9A);
    count_busy(n);
    chk("R2 busy length", n + 0, DEPTH);
    chk_blank("R2 ram blank");
    rd(2'b10, v);
    chk("R3 bit7 self clears", v, 8'h1A);
    chk("R6 blink over flash", {blink_en, flash_en}, 2'b10);
    chk("R7 bright", bright, 3'd2);
  endtask

  task automatic t_busy_ignore;
    logic [7:0] v; int n;
    wr(2'b10, 3'd0, 8'h80);
    wr(2'b00, 3'd3, 8'h41);
    wr(2'b10, 3'd0, 8'h07);
    count_busy(n);
    chk("R4 char ignored", cmem[3], 8'h20);
    rd(2'b10, v);
    chk("R4 ctl ignored", v, 8'h00);
  endtask

  task automatic t_decode;
    wr(2'b10, 3'd0, 8'h08);
    chk("R6 flash only", {blink_en, flash_en}, 2'b01);
    wr(2'b10, 3'd0, 8'h15);
    chk("R6 blink only", {blink_en, flash_en}, 2'b10);
    chk("R7 bright 5", bright, 3'd5);
  endtask

  task automatic t_selftest(input logic flt, input logic [7:0] exp);
    logic [7:0] v; int n;
    fault = flt;
    wr(2'b00, 3'd1, 8'h55);
    wr(2'b10, 3'd0, 8'h43);
    count_busy(n);
    fault = 0;
    chk(flt ? "R9 busy length" : "R8 busy length", n, DEPTH + 4);
    rd(2'b10, v);
    chk(flt ? "R9 result fail" : "R8 result pass", v, exp);
    chk_blank("R8 ram blank");
  endtask

  task automatic t_ro_bit;
    logic [7:0] v;
    wr(2'b10, 3'd0, 8'h01);
    rd(2'b10, v);
    chk("R5 result kept", v, 8'h21);
    chk("R5 test_pass pin", test_pass, 1);
  endtask

  task automatic t_ro_bit_set;
    logic [7:0] v;
    wr(2'b10, 3'd0, 8'h20);
    rd(2'b10, v);
    chk("R5 result not set", v, 8'h00);
  endtask

  task automatic t_read_mux;
    logic [7:0] v;
    wr(2'b10, 3'd0, 8'h0B);
    rd(2'b00, v);
    chk("R11 rdata other space", v, 8'h00);
    rd(2'b10, v);
    chk("R11 rdata ctl", v, 8'h0B);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_host_ram();
    t_reset();
    t_ro_bit_set();
    t_read_mux();
    t_decode();
    t_host_ram();
    t_clear();
    t_busy_ignore();
    t_selftest(1'b0, 8'h23);
    t_ro_bit();
    t_selftest(1'b1, 8'h03);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule